// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM read or write burst. A controller pulses a start strobe. With the strobe it gives the starting column, a burst length code, a wrap-order bit, and the direction of the access. From the next clock the block drives one column per cycle. Two flags go with the column: a valid flag while the burst runs, and a last flag on the final beat.

Fixed-length bursts stay inside the aligned block of 2, 4 or 8 columns that holds the start column. Inside that block the order is either sequential (the low bits count up and wrap) or interleaved (the low bits are the start bits XOR the beat index). A full-page burst walks every column of the row in turn, wraps from the top column back to column 0, and runs until the controller ends it.

A terminate input models a burst stop or a precharge and ends the burst at once. A new start cuts off any burst in progress. A single-write option shortens every write to one beat and leaves reads at the programmed length.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: A start sampled on a rising edge makes the next cycle carry valid high and the column equal to the start column. A start given while a burst runs replaces that burst in the same way.
- R2: Burst length codes: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives a full page. Codes 3'b100 to 3'b110 give 1 beat. Without terminate or restart, valid stays high for exactly that many consecutive cycles and then falls.
- R3: The last flag is high only on the final beat of a fixed-length burst. It is never high during a full-page burst.
- R4: With the wrap bit at 0 (sequential), beat i of a burst of length BL carries the start column with its low log2(BL) bits replaced by (start low bits + i) mod BL. The upper bits do not change.
- R5: With the wrap bit at 1 (interleaved), beat i carries the start column with its low log2(BL) bits replaced by (start low bits XOR i). The upper bits do not change.
- R6: A full-page burst gives column (start + i) mod 256 on beat i, whatever the wrap bit says. It continues past the top column and keeps running until terminate or a new start.
- R7: Terminate sampled high on an edge without a start makes valid low in the next cycle. When start and terminate arrive together, the start wins.
- R8: With single-write mode on, a write (direction input 1) lasts one beat with last high, and a read uses the programmed length. With the mode off, writes use the programmed length.
- R9: During and right after reset, valid and last are low and the column output is 0. The column output is also 0 whenever valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new burst this cycle |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst length code |
| wrap_ilv | input | 1 | 0 sequential, 1 interleaved |
| is_write | input | 1 | 1 when the burst is a write |
| single_wr | input | 1 | Single-write mode enable |
| term | input | 1 | Burst stop or precharge: end the burst |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is present this cycle |
| col_last | output | 1 | Current beat is the final one |

## Verification
The assertions assume that the inputs are stable around the rising edge. They also assume that start and terminate are single-cycle requests that the controller may raise in any cycle, including during a burst or in the same cycle as each other. They rely on the stated priority of start over terminate. The stimulus changes every input on the falling edge only. It sweeps every start column against every fixed length and both wrap orders. It then pulses terminate and restart at chosen beats, including together, so each priority case occurs while the properties are active.

// File: rtl/sdcbg_pkg.sv
package sdcbg_pkg;
    localparam int COL_W   = 8;
    localparam int CODE_W  = 3;

    typedef enum logic [CODE_W-1:0] {
        LEN_1    = 3'b000,
        LEN_2    = 3'b001,
        LEN_4    = 3'b010,
        LEN_8    = 3'b011,
        LEN_PAGE = 3'b111
    } len_code_e;

    typedef struct packed {
        logic             active;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] len_m1;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] base;
    } burst_state_t;
endpackage

// File: rtl/sdcbg_len_decode.sv
module sdcbg_len_decode
    import sdcbg_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic [CODE_W-1:0] len_code,
    input  logic              is_write,
    input  logic              single_wr,
    output logic [W-1:0]      len_m1,
    output logic [W-1:0]      mask,
    output logic              full
);
    logic [1:0] shift_d;
    logic       full_d;

    always_comb begin
        full_d  = 1'b0;
        shift_d = 2'd0;
        case (len_code)
            LEN_1:    shift_d = 2'd0;
            LEN_2:    shift_d = 2'd1;
            LEN_4:    shift_d = 2'd2;
            LEN_8:    shift_d = 2'd3;
            LEN_PAGE: full_d  = 1'b1;
            default:  shift_d = 2'd0;
        endcase
        // writes collapse to one beat in single-write mode
        if (single_wr && is_write) begin
            full_d  = 1'b0;
            shift_d = 2'd0;
        end
    end

    assign full   = full_d;
    assign len_m1 = full_d ? {W{1'b1}} : ((W'(1) << shift_d) - W'(1));
    assign mask   = full_d ? {W{1'b1}} : ((W'(1) << shift_d) - W'(1));
endmodule

// File: rtl/sdcbg_beat_ctrl.sv
module sdcbg_beat_ctrl
    import sdcbg_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         term,
    input  logic [W-1:0] start_col,
    input  logic         ilv_in,
    input  logic [W-1:0] len_m1_in,
    input  logic [W-1:0] mask_in,
    input  logic         full_in,
    output logic         active,
    output logic         last,
    output logic         ilv,
    output logic [W-1:0] base,
    output logic [W-1:0] cnt,
    output logic [W-1:0] mask
);
    burst_state_t st_d, st_q;
    logic         last_q;

    assign last_q = st_q.active && !st_q.full && (st_q.cnt == st_q.len_m1);

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.full   = full_in;
            st_d.ilv    = ilv_in && !full_in;
            st_d.cnt    = '0;
            st_d.len_m1 = len_m1_in;
            st_d.mask   = mask_in;
            st_d.base   = start_col;
        end else if (term) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (last_q) st_d.active = 1'b0;
            else        st_d.cnt    = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign last   = last_q;
    assign ilv    = st_q.ilv;
    assign base   = st_q.base;
    assign cnt    = st_q.cnt;
    assign mask   = st_q.mask;

    p_last_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !active);
    p_term_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !active);
    p_page_nolast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.full) |-> !last);
    p_run_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && !term) |=> active);
endmodule

// File: rtl/sdcbg_addr_calc.sv
module sdcbg_addr_calc
    import sdcbg_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         active,
    input  logic         ilv,
    input  logic [W-1:0] base,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] mask,
    output logic [W-1:0] col
);
    logic [W-1:0] sum_d;
    logic [W-1:0] mix_d;

    assign sum_d = base + cnt;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (!mask[b])  mix_d[b] = base[b];
            else if (ilv)  mix_d[b] = base[b] ^ cnt[b];
            else           mix_d[b] = sum_d[b];
        end
    end

    assign col = active ? mix_d : '0;
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
    import sdcbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [CODE_W-1:0] len_code,
    input  logic              wrap_ilv,
    input  logic              is_write,
    input  logic              single_wr,
    input  logic              term,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              col_last
);
    logic [COL_W-1:0] dec_len_m1, dec_mask;
    logic             dec_full;
    logic             ctl_ilv;
    logic [COL_W-1:0] ctl_base, ctl_cnt, ctl_mask;

    sdcbg_len_decode #(.W(COL_W)) u_dec (
        .len_code (len_code),
        .is_write (is_write),
        .single_wr(single_wr),
        .len_m1   (dec_len_m1),
        .mask     (dec_mask),
        .full     (dec_full)
    );

    sdcbg_beat_ctrl #(.W(COL_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .term     (term),
        .start_col(start_col),
        .ilv_in   (wrap_ilv),
        .len_m1_in(dec_len_m1),
        .mask_in  (dec_mask),
        .full_in  (dec_full),
        .active   (col_valid),
        .last     (col_last),
        .ilv      (ctl_ilv),
        .base     (ctl_base),
        .cnt      (ctl_cnt),
        .mask     (ctl_mask)
    );

    sdcbg_addr_calc #(.W(COL_W)) u_addr (
        .active(col_valid),
        .ilv   (ctl_ilv),
        .base  (ctl_base),
        .cnt   (ctl_cnt),
        .mask  (ctl_mask),
        .col   (col_addr)
    );

    p_start_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_addr == $past(start_col)));
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && single_wr && is_write) |=> col_last);
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_addr == '0 && !col_last));
endmodule

// File: tb/sdram_col_burst_gen_tb.sv
module sdram_col_burst_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       wrap_ilv = 1'b0;
    logic       is_write = 1'b0;
    logic       single_wr = 1'b0;
    logic       term = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sdram_col_burst_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_code(len_code), .wrap_ilv(wrap_ilv), .is_write(is_write),
        .single_wr(single_wr), .term(term), .col_addr(col_addr),
        .col_valid(col_valid), .col_last(col_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int bl, input int ilv, input int i);
        int lo;
        int blk;
        if (bl == 256) return (s + i) % 256;
        lo  = s % bl;
        blk = s - lo;
        if (ilv != 0) return blk + (lo ^ i);
        return blk + ((lo + i) % bl);
    endfunction

    // launch on a falling edge; returns at falling edge where beat 0 shows
    task automatic launch(input int s, input int code, input int ilv, input int wr, input int sw);
        start_col = 8'(s); len_code = 3'(code); wrap_ilv = ilv[0];
        is_write = wr[0]; single_wr = sw[0]; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_beats(input string req, input int s, input int bl,
                               input int ilv, input int n, input bit lastchk);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(col_valid), 1);
            chk(req, int'(col_addr), exp_col(s, bl, ilv, i));
            if (lastchk) chk("R3", int'(col_last), (i == n - 1) ? 1 : 0);
            else         chk("R6", int'(col_last), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < 60000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", int'(col_valid), 0);
        chk("R9", int'(col_last), 0);
        chk("R9", int'(col_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", int'(col_valid), 0);

        // R2 R4 R5: sweep every start column, fixed lengths, both orders
        for (int code = 0; code < 4; code++) begin
            for (int ilv = 0; ilv < 2; ilv++) begin
                for (int s = 0; s < 256; s++) begin
                    launch(s, code, ilv, 0, 0);
                    check_beats(ilv != 0 ? "R5" : "R4", s, 1 << code, ilv, 1 << code, 1'b1);
                    chk("R2", int'(col_valid), 0);
                    chk("R9", int'(col_addr), 0);
                end
            end
        end

        // R2: reserved codes give one beat
        for (int code = 4; code < 7; code++) begin
            launch(77, code, 0, 0, 0);
            check_beats("R2", 77, 1, 0, 1, 1'b1);
            chk("R2", int'(col_valid), 0);
        end

        // R6: full page from 250, both wrap bits, crosses column 255
        for (int ilv = 0; ilv < 2; ilv++) begin
            launch(250, 7, ilv, 0, 0);
            check_beats("R6", 250, 256, 0, 300, 1'b0);
            chk("R6", int'(col_valid), 1);
            term = 1'b1;
            @(posedge clk); @(negedge clk);
            term = 1'b0;
            chk("R7", int'(col_valid), 0);
            chk("R7", int'(col_addr), 0);
        end

        // R7: terminate mid fixed burst
        launch(16, 3, 0, 0, 0);
        check_beats("R4", 16, 8, 0, 3, 1'b0);
        term = 1'b1;
        @(posedge clk); @(negedge clk);
        term = 1'b0;
        chk("R7", int'(col_valid), 0);
        chk("R7", int'(col_last), 0);

        // R1: restart during burst
        launch(5, 3, 0, 0, 0);
        check_beats("R1", 5, 8, 0, 2, 1'b0);
        launch(100, 2, 1, 0, 0);
        check_beats("R1", 100, 4, 1, 4, 1'b1);
        chk("R1", int'(col_valid), 0);

        // R7: start and terminate together, start wins
        launch(40, 3, 0, 0, 0);
        term = 1'b1;
        launch(201, 1, 0, 0, 0);
        term = 1'b0;
        check_beats("R7", 201, 2, 0, 2, 1'b1);
        chk("R7", int'(col_valid), 0);

        // R8: single-write mode
        launch(33, 3, 0, 1, 1);
        check_beats("R8", 33, 1, 0, 1, 1'b1);
        chk("R8", int'(col_valid), 0);
        launch(33, 7, 0, 1, 1);
        check_beats("R8", 33, 1, 0, 1, 1'b1);
        chk("R8", int'(col_valid), 0);
        launch(33, 3, 1, 0, 1);
        check_beats("R8", 33, 8, 1, 8, 1'b1);
        chk("R8", int'(col_valid), 0);
        launch(33, 3, 0, 1, 0);
        check_beats("R8", 33, 8, 0, 8, 1'b1);
        chk("R8", int'(col_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule